// File: doc/BRIEF.md
# Serial Input Edge Event Unit

This unit sits behind a serial input expander's shift engine. Each time the shift engine finishes a scan, it presents all the captured input bits at once on a parallel bus and pulses a strobe. The unit compares every bit with the value captured at the previous strobe. Where the change matches the direction enabled for that pin, it sets a sticky status bit. Any set status bit drives one combined interrupt line.

Software programs a 2-bit edge selector for each pin. The selectors are packed eight to a 16-bit word, one word per bank of eight pins. Software reads the status bytes to find which pins fired, then clears them by writing ones. Pins at or above the input count are output-only and can never raise an event.

Top module: `sgpio_evt_unit`

## Requirements
- R1: After reset, every configuration word and every status byte reads 0, and `irq` is low.
- R2: The configuration word for bank b is written and read, all 16 bits, at byte address 0x10 + 2*b. Pin n of the bank owns bits [2n+1:2n].
- R3: Selector bit 0 (code 01) makes a 0-to-1 change of the pin between two successive scans set its status bit.
- R4: Selector bit 1 (code 10) makes a 1-to-0 change between two successive scans set its status bit.
- R5: Code 11 reacts to either change, and code 00 reacts to none. Writing code 00 leaves any status bit that is already set unchanged.
- R6: Edges are judged only when `scan_done` is high. When the strobe is low, changes on `scan_bits` set nothing and do not replace the stored previous scan.
- R7: The status byte of bank b is at byte address 0x20 + b, and bit n is pin 8b+n. Writing a 1 to a bit (from `reg_wdata[7:0]`) clears it, writing a 0 leaves it unchanged, and writing 0xFF clears the whole bank.
- R8: If a detected event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: Pins with index at or above `NUM_INPUTS` never set a status bit.
- R10: `irq` is high exactly while at least one status bit in any bank is set.
- R11: The stored previous scan is 0 after reset, so a 1 in the first scan counts as a rising change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_done | input | 1 | One-cycle strobe: a scan has completed |
| scan_bits | input | NUM_BANKS*8 | Input bits captured by the scan |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 6 | Register byte address for both reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined event interrupt |

## Verification
The bench sweeps every selector code against every pair of successive pin values, over all 64 pins at once.
- A swapped selector bit would show up as status bits set on the wrong direction.
- Judging edges against the last clock sample instead of the last strobed scan would show up when `scan_bits` moves without a strobe.
- A clear that overrides a same-cycle event would lose that event.
- A selector of 00 that also clears would wipe status bits that were already pending.
- Missing output-pin gating would set bits 60 to 63 when the bench instance has 60 inputs.

// File: rtl/sgpio_evt_pkg.sv
package sgpio_evt_pkg;
    localparam int PINS_PER_BANK = 8;
    localparam int SEL_W         = 2;
    localparam int CFG_W         = PINS_PER_BANK * SEL_W;
    localparam int ADDR_W        = 6;
    localparam int DATA_W        = 16;

    // Bit 0 of a selector enables rising detection, bit 1 enables falling detection.
    typedef enum logic [SEL_W-1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    localparam logic [1:0] CFG_REGION = 2'b01;  // 0x10..0x1F
    localparam logic [2:0] STS_REGION = 3'b100; // 0x20..0x27
endpackage

// File: rtl/sgpio_evt_bank_detect.sv
module sgpio_evt_bank_detect
    import sgpio_evt_pkg::*;
#(
    parameter int NUM_VALID = PINS_PER_BANK
) (
    input  logic [PINS_PER_BANK-1:0] prev_bits,
    input  logic [PINS_PER_BANK-1:0] cur_bits,
    input  logic [CFG_W-1:0]         sel_word,
    output logic [PINS_PER_BANK-1:0] evt
);
    for (genvar n = 0; n < PINS_PER_BANK; n++) begin : g_pin
        if (n < NUM_VALID) begin : g_in
            logic rise_seen;
            logic fall_seen;
            assign rise_seen = ~prev_bits[n] &  cur_bits[n];
            assign fall_seen =  prev_bits[n] & ~cur_bits[n];
            assign evt[n] = (rise_seen & sel_word[SEL_W*n])
                          | (fall_seen & sel_word[SEL_W*n+1]);
        end else begin : g_out
            assign evt[n] = 1'b0;
        end
    end
endmodule

// File: rtl/sgpio_evt_reg_decode.sv
module sgpio_evt_reg_decode
    import sgpio_evt_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_BANKS-1:0] cfg_hit,
    output logic [NUM_BANKS-1:0] sts_hit
);
    always_comb begin
        cfg_hit = '0;
        sts_hit = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr[5:4] == CFG_REGION && !addr[0] && int'(addr[3:1]) == b)
                cfg_hit[b] = 1'b1;
            if (addr[5:3] == STS_REGION && int'(addr[2:0]) == b)
                sts_hit[b] = 1'b1;
        end
    end
endmodule

// File: rtl/sgpio_evt_irq_tree.sv
module sgpio_evt_irq_tree
    import sgpio_evt_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] sts_bits,
    output logic                               irq
);
    logic [NUM_BANKS-1:0] bank_any;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_any[b] = |sts_bits[b*PINS_PER_BANK +: PINS_PER_BANK];
    end

    assign irq = |bank_any;
endmodule

// File: rtl/sgpio_evt_unit.sv
module sgpio_evt_unit
    import sgpio_evt_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int NUM_INPUTS = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               scan_done,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] scan_bits,
    input  logic                               reg_wr_en,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    output logic                               irq
);
    localparam int NUM_PINS = NUM_BANKS * PINS_PER_BANK;

    typedef struct packed {
        logic [NUM_BANKS-1:0][CFG_W-1:0]         cfg;
        logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0] sts;
        logic [NUM_PINS-1:0]                     prev;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_BANKS-1:0] cfg_hit;
    logic [NUM_BANKS-1:0] sts_hit;
    logic [NUM_PINS-1:0]  evt_flat;
    logic [NUM_PINS-1:0]  sts_flat;

    sgpio_evt_reg_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .addr    (reg_addr),
        .cfg_hit (cfg_hit),
        .sts_hit (sts_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_det
        localparam int BANK_IN =
            (NUM_INPUTS >= (b + 1) * PINS_PER_BANK) ? PINS_PER_BANK :
            (NUM_INPUTS >  b * PINS_PER_BANK)       ? NUM_INPUTS - b * PINS_PER_BANK : 0;
        sgpio_evt_bank_detect #(.NUM_VALID(BANK_IN)) u_det (
            .prev_bits (st_q.prev[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .cur_bits  (scan_bits[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .sel_word  (st_q.cfg[b]),
            .evt       (evt_flat[b*PINS_PER_BANK +: PINS_PER_BANK])
        );
        assign sts_flat[b*PINS_PER_BANK +: PINS_PER_BANK] = st_q.sts[b];
    end

    // Next-state computation
    always_comb begin
        logic [PINS_PER_BANK-1:0] clr_mask;
        logic [PINS_PER_BANK-1:0] set_mask;
        st_d = st_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_wr_en && cfg_hit[b])
                st_d.cfg[b] = reg_wdata;
            clr_mask = (reg_wr_en && sts_hit[b]) ? reg_wdata[PINS_PER_BANK-1:0] : '0;
            set_mask = scan_done ? evt_flat[b*PINS_PER_BANK +: PINS_PER_BANK] : '0;
            // A same-cycle event wins over a clear.
            st_d.sts[b] = (st_q.sts[b] & ~clr_mask) | set_mask;
        end
        if (scan_done)
            st_d.prev = scan_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cfg_hit[b])
                reg_rdata = reg_rdata | st_q.cfg[b];
            if (sts_hit[b])
                reg_rdata = reg_rdata | {{(DATA_W-PINS_PER_BANK){1'b0}}, st_q.sts[b]};
        end
    end

    sgpio_evt_irq_tree #(.NUM_BANKS(NUM_BANKS)) u_irq (
        .sts_bits (sts_flat),
        .irq      (irq)
    );
endmodule

// File: rtl/sgpio_evt_checker.sv
module sgpio_evt_checker
    import sgpio_evt_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int NUM_INPUTS = 64
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               scan_done,
    input logic                               reg_wr_en,
    input logic [ADDR_W-1:0]                  reg_addr,
    input logic [DATA_W-1:0]                  reg_wdata,
    input logic                               irq,
    input logic [NUM_BANKS*PINS_PER_BANK-1:0] sts_flat
);
    localparam int W = NUM_BANKS * PINS_PER_BANK;

    logic [W-1:0] in_mask;
    logic [W-1:0] clr_m;

    always_comb begin
        for (int i = 0; i < W; i++)
            in_mask[i] = (i < NUM_INPUTS);
    end

    always_comb begin
        clr_m = '0;
        if (reg_wr_en && reg_addr[5:3] == STS_REGION && int'(reg_addr[2:0]) < NUM_BANKS)
            clr_m[int'(reg_addr[2:0])*PINS_PER_BANK +: PINS_PER_BANK] = reg_wdata[PINS_PER_BANK-1:0];
    end

    a_r10_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|sts_flat));

    a_r6_quiet_without_scan: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done |=> ((sts_flat & ~$past(sts_flat)) == '0));

    a_r7_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr_m) && !scan_done) |=> ((sts_flat & $past(clr_m)) == '0));

    a_r9_output_pins_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_flat & ~in_mask) == '0);
endmodule

bind sgpio_evt_unit sgpio_evt_checker #(
    .NUM_BANKS  (NUM_BANKS),
    .NUM_INPUTS (NUM_INPUTS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_done (scan_done),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .sts_flat  (sts_flat)
);

// File: tb/tb_sgpio_evt_unit.sv
module tb_sgpio_evt_unit;
    localparam int NB   = 8;
    localparam int NIN  = 60;
    localparam int NP   = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_done = 1'b0;
    logic [NP-1:0] scan_bits = '0;
    logic          reg_wr_en = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq;

    always #5 clk = ~clk;

    sgpio_evt_unit #(.NUM_BANKS(NB), .NUM_INPUTS(NIN)) dut (
        .clk(clk), .rst_n(rst_n), .scan_done(scan_done), .scan_bits(scan_bits),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [NP-1:0] m_sts  = '0;
    logic [NP-1:0] m_prev = '0;
    logic [15:0]   m_cfg [NB];
    logic [63:0]   rng = 64'h9E37_79B9_7F4A_7C15;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rng(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // One clock cycle with optional scan strobe and optional register write.
    // The model is updated with the next-state rules of the requirements.
    task automatic step(input bit sd, input logic [NP-1:0] data,
                        input bit we, input logic [5:0] a, input logic [15:0] wd);
        logic [NP-1:0] evt;
        logic [NP-1:0] clr;
        evt = '0;
        clr = '0;
        if (sd) begin
            for (int i = 0; i < NIN; i++) begin
                logic [1:0] s;
                s = m_cfg[i/8][2*(i%8) +: 2];
                if ((!m_prev[i] && data[i] && s[0]) || (m_prev[i] && !data[i] && s[1]))
                    evt[i] = 1'b1;
            end
        end
        if (we && a[5:3] == 3'b100)
            clr[int'(a[2:0])*8 +: 8] = wd[7:0];
        m_sts = (m_sts & ~clr) | evt;
        if (sd) m_prev = data;
        if (we && a[5:4] == 2'b01 && !a[0])
            m_cfg[int'(a[3:1])] = wd;
        @(negedge clk);
        scan_done = sd;
        scan_bits = data;
        reg_wr_en = we;
        reg_addr  = a;
        reg_wdata = wd;
        @(negedge clk);
        scan_done = 1'b0;
        reg_wr_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] wd);
        step(1'b0, scan_bits, 1'b1, a, wd);
    endtask

    task automatic scan(input logic [NP-1:0] data);
        step(1'b1, data, 1'b0, 6'h00, 16'h0);
    endtask

    task automatic clear_all();
        for (int b = 0; b < NB; b++) wr(6'h20 + 6'(b), 16'h00FF);
    endtask

    task automatic set_all_cfg(input logic [15:0] w);
        for (int b = 0; b < NB; b++) wr(6'h10 + 6'(2*b), w);
    endtask

    task automatic check_all(input string req);
        for (int b = 0; b < NB; b++) begin
            reg_addr = 6'h20 + 6'(b);
            #1;
            chk(reg_rdata == {8'h00, m_sts[b*8 +: 8]}, req, reg_rdata, {8'h00, m_sts[b*8 +: 8]});
            reg_addr = 6'h10 + 6'(2*b);
            #1;
            chk(reg_rdata == m_cfg[b], req, reg_rdata, m_cfg[b]);
        end
        chk(irq == (|m_sts), req, {15'h0, irq}, {15'h0, |m_sts});
    endtask

    initial begin
        #(10 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) m_cfg[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check_all("R1 reset");

        // R2: per-bank configuration words
        for (int b = 0; b < NB; b++) wr(6'h10 + 6'(2*b), 16'hA5C3 ^ 16'(b * 16'h1111));
        check_all("R2 config readback");

        // R11 and R9: first scan after reset with all ones and rising selected
        set_all_cfg(16'h5555);
        scan({NP{1'b1}});
        check_all("R11 first scan rises");
        reg_addr = 6'h27;
        #1;
        chk(reg_rdata == 16'h000F, "R9 output pins silent", reg_rdata, 16'h000F);

        // R7: write-one clear, write-zero keeps, 0xFF clears the bank
        wr(6'h20, 16'h000F);
        check_all("R7 partial clear");
        wr(6'h21, 16'h0000);
        check_all("R7 zero write keeps");
        clear_all();
        check_all("R7 full clear");
        chk(irq == 1'b0, "R10 irq low when clear", {15'h0, irq}, 16'h0);

        // R6: the bus moves with no strobe; nothing happens and prev stays all ones
        step(1'b0, '0, 1'b0, 6'h00, 16'h0);
        check_all("R6 no strobe");
        scan({NP{1'b1}});
        check_all("R6 compare to last strobed scan");

        // R3/R4/R5: every selector code against every transition pair
        for (int code = 0; code < 4; code++) begin
            string tag;
            tag = (code == 1) ? "R3 rising" : (code == 2) ? "R4 falling" : "R5 any/off";
            set_all_cfg({8{2'(code)}});
            for (int t = 0; t < 4; t++) begin
                logic a0, b0;
                a0 = t[1];
                b0 = t[0];
                scan({NP{a0}});
                clear_all();
                scan({NP{b0}});
                check_all(tag);
            end
        end

        // R5: selector 00 keeps already pending bits
        set_all_cfg(16'hFFFF);
        scan('0);
        clear_all();
        scan(64'h00FF_00FF_00FF_00FF);
        set_all_cfg(16'h0000);
        scan('0);
        check_all("R5 off keeps pending");
        clear_all();

        // R8: event and clear of the same bits in one cycle
        set_all_cfg(16'h5555);
        scan('0);
        step(1'b1, 64'h0000_0000_00F0_0000, 1'b1, 6'h22, 16'h00FF);
        check_all("R8 event beats clear");
        step(1'b1, 64'h0000_0000_00F0_0000, 1'b1, 6'h22, 16'h00F0);
        check_all("R8 clear without event");

        // R10 and mixed traffic: pseudo-random selectors, scans and clears
        for (int it = 0; it < 60; it++) begin
            rng = next_rng(rng);
            if (rng[3:0] == 4'h0)
                wr(6'h10 + 6'(2 * int'(rng[6:4])), rng[31:16]);
            rng = next_rng(rng);
            step(rng[0], rng, rng[1], 6'h20 + 6'(rng[10:8]), {8'h00, rng[23:16]});
            check_all("R10 mixed traffic");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule